// File: doc/BRIEF.md
# Steering target resolver

The resolver takes the address of a replicated register. It returns a group/instance pair that steers an access to a copy of that register that is powered and not fused off. Each steering class owns a small table of inclusive address windows, and the tables are fixed by parameters. The classes are tried in a fixed priority order, and the first class whose table holds the address selects the rule that builds the pair.

Four classes derive the pair from the unit-enable state given on the inputs:

- The bank class takes a 3-bit bank fuse word. Each set fuse bit stands for two enabled banks.
- The slice class uses the slice enable mask.
- The per-slice node class also uses the slice enable mask.
- The subunit class uses the index of the first enabled subunit.

The always-present class steers to (0,0). An address outside every table gets a configured default pair. A request is presented with a one-cycle strobe, and the result appears on registered outputs in the following cycle. The outputs hold that result until the next request.

Top module: `steer_resolver`

## Requirements
- R1: An address matches a window when start <= address <= end, with both ends inclusive. One address above the end, or one below the start, does not match that window.
- R2: Classes are tried in priority order, and the first class with a matching window decides. The order and the class_o codes are: bank = 0, slice = 1, node = 2, subunit = 3, always-present = 4. With the default tables, 0x00B000-0x00B3FF lies in both the always-present table and either the bank or the node table, and the lower code wins.
- R3: An address that matches no class gives hit_o = 0, class_o = 7, err_o = 0 and the default pair. With default parameters the default pair is group 2, instance 3.
- R4: For the bank class, bit i of fuse_i enables banks 2i and 2i+1. group_o is 0, and inst_o is the index of the lowest enabled bank, which is 2 times the index of the lowest set fuse bit.
- R5: For the slice class, group_o is the index of the lowest set bit of slice_i, and inst_o is 0.
- R6: For the node class, group_o is the index of the lowest set bit of slice_i shifted left by one, and inst_o is 0.
- R7: For the subunit class, group_o is sub_idx_i divided by 4 and inst_o is sub_idx_i modulo 4. Here 4 is the default number of subunits per group.
- R8: For the always-present class, the pair is (0,0) and err_o is 0, whatever the unit-enable inputs hold.
- R9: If the bank class is selected with fuse_i all zero, or the slice or node class is selected with slice_i all zero, the pair is (0,0) and err_o is 1. In every other case err_o is 0.
- R10: A request strobed on valid_i at one clock edge shows on the outputs after that edge, and valid_o is high for exactly that following cycle. Without a strobe, group_o, inst_o, hit_o, class_o and err_o keep their values.
- R11: While rst_ni is low, valid_o, hit_o, group_o, inst_o and err_o are 0 and class_o is 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| addr_i | input | AW (24) | Register address to resolve |
| fuse_i | input | FUSE_W (3) | Bank fuse word, one bit per bank pair |
| slice_i | input | SLICE_W (4) | Slice enable mask |
| sub_idx_i | input | SUB_W (6) | Index of the first enabled subunit |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| group_o | output | GRP_W (4) | Steering group |
| inst_o | output | INST_W (4) | Steering instance |
| hit_o | output | 1 | Address matched some class |
| class_o | output | 3 | Matched class code, 7 when nothing matched |
| err_o | output | 1 | Selected class had an all-zero enable mask |

## Verification
The assertions check the relations that hold on every cycle:

- the one-cycle delay from strobe to valid,
- holding of the outputs between requests,
- the default pair and class code on a miss,
- a zero pair whenever the error flag is set,
- the structural shape of each class's pair: an even bank instance, a zero instance for the slice and node classes, an even node group, and (0,0) for the always-present class.

Only the bench scenarios can show the rest. These cover the window endpoints and the addresses one step outside them, the winner in overlapping windows, the lowest-set-bit values and the subunit division, and the all-zero enable masks.

// File: rtl/steer_pkg.sv
package steer_pkg;
  localparam int NUM_CLS = 5;

  typedef enum logic [2:0] {
    CLS_BANK    = 3'd0,
    CLS_SLICE   = 3'd1,
    CLS_NODE    = 3'd2,
    CLS_SUBUNIT = 3'd3,
    CLS_ZERO    = 3'd4,
    CLS_NONE    = 3'd7
  } steer_cls_e;
endpackage

// File: rtl/steer_first_set.sv
module steer_first_set #(
  parameter int W = 4,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          none_o
);
  always_comb begin
    idx_o = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (vec_i[k]) idx_o = IW'(k);
    end
    none_o = ~|vec_i;
  end
endmodule

// File: rtl/steer_range_match.sv
module steer_range_match #(
  parameter int AW = 24,
  parameter int N  = 3,
  parameter logic [N*AW-1:0] LO = '0,
  parameter logic [N*AW-1:0] HI = '0
) (
  input  logic [AW-1:0] addr_i,
  output logic          hit_o
);
  logic [N-1:0] win_hit;

  // an unused slot is written with start > end and never matches
  for (genvar r = 0; r < N; r++) begin : g_win
    assign win_hit[r] = (addr_i >= LO[r*AW +: AW]) && (addr_i <= HI[r*AW +: AW]);
  end

  assign hit_o = |win_hit;
endmodule

// File: rtl/steer_resolver.sv
module steer_resolver
  import steer_pkg::*;
#(
  parameter int AW          = 24,
  parameter int RNG         = 3,
  parameter int FUSE_W      = 3,
  parameter int SLICE_W     = 4,
  parameter int SUB_W       = 6,
  parameter int SUB_PER_GRP = 4,
  parameter int GRP_W       = 4,
  parameter int INST_W      = 4,
  parameter int DEF_GROUP   = 2,
  parameter int DEF_INST    = 3,
  // slot index = class*RNG + slot, slot 0 in the lowest bits
  parameter logic [NUM_CLS*RNG*AW-1:0] RNG_LO = {
    24'h00B000, 24'h00C800, 24'h004000,
    24'hFFFFFF, 24'h009680, 24'h005200,
    24'hFFFFFF, 24'h00D800, 24'h00B000,
    24'hFFFFFF, 24'h00E900, 24'h00DD00,
    24'hFFFFFF, 24'hFFFFFF, 24'h00B100},
  parameter logic [NUM_CLS*RNG*AW-1:0] RNG_HI = {
    24'h00B3FF, 24'h00CFFF, 24'h004AFF,
    24'h000000, 24'h0096FF, 24'h0052FF,
    24'h000000, 24'h00D8FF, 24'h00B0FF,
    24'h000000, 24'h00FFFF, 24'h00DDFF,
    24'h000000, 24'h000000, 24'h00B3FF}
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [FUSE_W-1:0]  fuse_i,
  input  logic [SLICE_W-1:0] slice_i,
  input  logic [SUB_W-1:0]   sub_idx_i,
  output logic               valid_o,
  output logic [GRP_W-1:0]   group_o,
  output logic [INST_W-1:0]  inst_o,
  output logic               hit_o,
  output logic [2:0]         class_o,
  output logic               err_o
);
  localparam int BANK_W  = 2 * FUSE_W;
  localparam int BIDX_W  = (BANK_W > 1) ? $clog2(BANK_W) : 1;
  localparam int SIDX_W  = (SLICE_W > 1) ? $clog2(SLICE_W) : 1;
  localparam int TBL_W   = RNG * AW;
  localparam logic [SUB_W-1:0] PER_GRP = SUB_W'(SUB_PER_GRP);

  logic [NUM_CLS-1:0] cls_hit;
  logic [BANK_W-1:0]  bank_mask;
  logic [BIDX_W-1:0]  bank_idx;
  logic               bank_none;
  logic [SIDX_W-1:0]  slice_idx;
  logic               slice_none;

  steer_cls_e         sel;
  logic [GRP_W-1:0]   nxt_grp;
  logic [INST_W-1:0]  nxt_inst;
  logic               nxt_err;

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    steer_range_match #(
      .AW (AW),
      .N  (RNG),
      .LO (RNG_LO[c*TBL_W +: TBL_W]),
      .HI (RNG_HI[c*TBL_W +: TBL_W])
    ) u_match (
      .addr_i (addr_i),
      .hit_o  (cls_hit[c])
    );
  end

  // one fuse bit enables a pair of banks
  for (genvar f = 0; f < FUSE_W; f++) begin : g_bank
    assign bank_mask[2*f +: 2] = {2{fuse_i[f]}};
  end

  steer_first_set #(.W(BANK_W)) u_bank_ffs (
    .vec_i  (bank_mask),
    .idx_o  (bank_idx),
    .none_o (bank_none)
  );

  steer_first_set #(.W(SLICE_W)) u_slice_ffs (
    .vec_i  (slice_i),
    .idx_o  (slice_idx),
    .none_o (slice_none)
  );

  // lowest class code wins
  always_comb begin
    sel = CLS_NONE;
    for (int c = NUM_CLS - 1; c >= 0; c--) begin
      if (cls_hit[c]) sel = steer_cls_e'(3'(c));
    end
  end

  always_comb begin
    nxt_grp  = '0;
    nxt_inst = '0;
    nxt_err  = 1'b0;
    unique case (sel)
      CLS_BANK: begin
        if (bank_none) nxt_err = 1'b1;
        else           nxt_inst = INST_W'(bank_idx);
      end
      CLS_SLICE: begin
        if (slice_none) nxt_err = 1'b1;
        else            nxt_grp = GRP_W'(slice_idx);
      end
      CLS_NODE: begin
        if (slice_none) nxt_err = 1'b1;
        else            nxt_grp = GRP_W'({slice_idx, 1'b0});
      end
      CLS_SUBUNIT: begin
        nxt_grp  = GRP_W'(sub_idx_i / PER_GRP);
        nxt_inst = INST_W'(sub_idx_i % PER_GRP);
      end
      CLS_ZERO: ;
      default: begin
        nxt_grp  = GRP_W'(DEF_GROUP);
        nxt_inst = INST_W'(DEF_INST);
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      group_o <= '0;
      inst_o  <= '0;
      hit_o   <= 1'b0;
      class_o <= CLS_NONE;
      err_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        group_o <= nxt_grp;
        inst_o  <= nxt_inst;
        hit_o   <= (sel != CLS_NONE);
        class_o <= sel;
        err_o   <= nxt_err;
      end
    end
  end
endmodule

// File: rtl/steer_resolver_sva.sv
module steer_resolver_sva #(
  parameter int GRP_W     = 4,
  parameter int INST_W    = 4,
  parameter int DEF_GROUP = 2,
  parameter int DEF_INST  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              valid_o,
  input logic [GRP_W-1:0]  group_o,
  input logic [INST_W-1:0] inst_o,
  input logic              hit_o,
  input logic [2:0]        class_o,
  input logic              err_o
);
  assert_valid_follows_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_drops_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(group_o) && $stable(inst_o) && $stable(hit_o)
                  && $stable(class_o) && $stable(err_o)));
  assert_miss_default_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !hit_o) |-> (class_o == 3'd7 && !err_o
                             && group_o == GRP_W'(DEF_GROUP) && inst_o == INST_W'(DEF_INST)));
  assert_err_zero_pair_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (group_o == '0 && inst_o == '0 && hit_o));
  assert_bank_shape_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && class_o == 3'd0) |-> (group_o == '0 && !inst_o[0]));
  assert_slice_shape_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && class_o == 3'd1) |-> (inst_o == '0));
  assert_node_shape_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && class_o == 3'd2) |-> (inst_o == '0 && !group_o[0]));
  assert_zero_pair_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && class_o == 3'd4) |-> (group_o == '0 && inst_o == '0 && !err_o));
endmodule

bind steer_resolver steer_resolver_sva #(
  .GRP_W     (GRP_W),
  .INST_W    (INST_W),
  .DEF_GROUP (DEF_GROUP),
  .DEF_INST  (DEF_INST)
) u_sva (.*);

// File: tb/tb_steer_resolver.sv
`timescale 1ns/1ps
module tb_steer_resolver;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [23:0] addr = '0;
  logic [2:0]  fuse = '0;
  logic [3:0]  slice = '0;
  logic [5:0]  sub = '0;
  logic        valid_o;
  logic [3:0]  group_o;
  logic [3:0]  inst_o;
  logic        hit_o;
  logic [2:0]  class_o;
  logic        err_o;

  typedef struct {
    logic [3:0] g;
    logic [3:0] i;
    logic       h;
    logic [2:0] c;
    logic       e;
    string      req;
  } exp_t;

  exp_t q[$];
  exp_t last;
  bit   have_last = 0;
  bit   done = 0;
  int   checks = 0;
  int   fails = 0;
  int   pushes = 0;
  int   pops = 0;

  always #2 clk = ~clk;

  steer_resolver dut (
    .clk_i (clk), .rst_ni (rst_n), .valid_i (valid), .addr_i (addr),
    .fuse_i (fuse), .slice_i (slice), .sub_idx_i (sub),
    .valid_o (valid_o), .group_o (group_o), .inst_o (inst_o),
    .hit_o (hit_o), .class_o (class_o), .err_o (err_o)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cmp(input exp_t x, input string req);
    chk(group_o == x.g, req, "group", group_o, x.g);
    chk(inst_o == x.i, req, "inst", inst_o, x.i);
    chk(hit_o == x.h, req, "hit", hit_o, x.h);
    chk(class_o == x.c, req, "class", class_o, x.c);
    chk(err_o == x.e, req, "err", err_o, x.e);
  endtask

  task automatic issue(input logic [23:0] a, input logic [2:0] f, input logic [3:0] s,
                       input logic [5:0] u, input logic [3:0] g, input logic [3:0] i,
                       input logic h, input logic [2:0] c, input logic e, input string req);
    exp_t x;
    @(negedge clk);
    addr = a; fuse = f; slice = s; sub = u; valid = 1'b1;
    x.g = g; x.i = i; x.h = h; x.c = c; x.e = e; x.req = req;
    q.push_back(x);
    pushes++;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    valid = 1'b0;
    addr = 24'hABCDEF; fuse = 3'b111; slice = 4'hF; sub = 6'd63;
    repeat (n - 1) @(negedge clk);
  endtask

  // monitor: pop on each result, otherwise outputs must hold
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (valid_o) begin
        if (q.size() == 0) begin
          chk(1'b0, "R10", "unexpected valid_o", 1, 0);
        end else begin
          last = q.pop_front();
          pops++;
          cmp(last, last.req);
          have_last = 1;
        end
      end else if (have_last) begin
        cmp(last, "R10");
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL R10 watchdog expired actual=%0d expected=%0d", pops, pushes);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(valid_o == 1'b0, "R11", "valid", valid_o, 0);
    chk(hit_o == 1'b0, "R11", "hit", hit_o, 0);
    chk(class_o == 3'd7, "R11", "class", class_o, 7);
    chk(group_o == 4'd0, "R11", "group", group_o, 0);
    chk(inst_o == 4'd0, "R11", "inst", inst_o, 0);
    chk(err_o == 1'b0, "R11", "err", err_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R4 bank window endpoints
    issue(24'h00B100, 3'b110, 4'h1, 6'd0, 4'd0, 4'd2, 1, 3'd0, 0, "R1");
    issue(24'h00B3FF, 3'b001, 4'h1, 6'd0, 4'd0, 4'd0, 1, 3'd0, 0, "R4");
    issue(24'h00B200, 3'b100, 4'h1, 6'd0, 4'd0, 4'd4, 1, 3'd0, 0, "R2");
    idle(3);
    // R1 one past every window end -> miss
    issue(24'h00B400, 3'b111, 4'hF, 6'd5, 4'd2, 4'd3, 0, 3'd7, 0, "R1");
    issue(24'h010000, 3'b111, 4'hF, 6'd5, 4'd2, 4'd3, 0, 3'd7, 0, "R1");
    issue(24'h00967F, 3'b111, 4'hF, 6'd5, 4'd2, 4'd3, 0, 3'd7, 0, "R1");
    issue(24'h000000, 3'b000, 4'h0, 6'd0, 4'd2, 4'd3, 0, 3'd7, 0, "R3");
    issue(24'h39B100, 3'b111, 4'hF, 6'd0, 4'd2, 4'd3, 0, 3'd7, 0, "R3");
    idle(2);
    // R5 slice
    issue(24'h00DD80, 3'b000, 4'b1010, 6'd0, 4'd1, 4'd0, 1, 3'd1, 0, "R5");
    issue(24'h00FFFF, 3'b000, 4'b1000, 6'd0, 4'd3, 4'd0, 1, 3'd1, 0, "R5");
    // R6 node, and R2 node over always-present
    issue(24'h00D800, 3'b000, 4'b0001, 6'd0, 4'd0, 4'd0, 1, 3'd2, 0, "R6");
    issue(24'h00D8FF, 3'b000, 4'b0010, 6'd0, 4'd2, 4'd0, 1, 3'd2, 0, "R6");
    issue(24'h00B0FF, 3'b000, 4'b0100, 6'd0, 4'd4, 4'd0, 1, 3'd2, 0, "R2");
    issue(24'h00B050, 3'b111, 4'b1100, 6'd0, 4'd4, 4'd0, 1, 3'd2, 0, "R2");
    idle(2);
    // R7 subunit
    issue(24'h005200, 3'b000, 4'h0, 6'd13, 4'd3, 4'd1, 1, 3'd3, 0, "R7");
    issue(24'h0096FF, 3'b000, 4'h0, 6'd6, 4'd1, 4'd2, 1, 3'd3, 0, "R7");
    issue(24'h009680, 3'b000, 4'h0, 6'd63, 4'd15, 4'd3, 1, 3'd3, 0, "R7");
    // R8 always-present, enables ignored
    issue(24'h004000, 3'b000, 4'h0, 6'd63, 4'd0, 4'd0, 1, 3'd4, 0, "R8");
    issue(24'h00CFFF, 3'b111, 4'hF, 6'd9, 4'd0, 4'd0, 1, 3'd4, 0, "R8");
    idle(4);
    // R9 all-zero enables
    issue(24'h00B150, 3'b000, 4'hF, 6'd0, 4'd0, 4'd0, 1, 3'd0, 1, "R9");
    issue(24'h00DD00, 3'b111, 4'h0, 6'd0, 4'd0, 4'd0, 1, 3'd1, 1, "R9");
    issue(24'h00D8A0, 3'b111, 4'h0, 6'd0, 4'd0, 4'd0, 1, 3'd2, 1, "R9");
    issue(24'h00B150, 3'b010, 4'h0, 6'd0, 4'd0, 4'd2, 1, 3'd0, 0, "R9");
    idle(5);

    chk(q.size() == 0, "R10", "queue left", q.size(), 0);
    chk(pops == pushes, "R10", "results", pops, pushes);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule